// File: doc/BRIEF.md
# Warp issue scheduler

This block decides which warp a multiprocessor issues from in each clock cycle. Blocks of threads are admitted one at a time through a valid/ready pair. The block is split into groups of 32 threads, and each group becomes a resident warp in a slot table. The final group of a block whose thread count is not a multiple of 32 carries a lane mask that enables only the lanes actually present. A scoreboard outside the block drives one operand-ready bit per slot. A slot is eligible when it is occupied and its bit is high.

Each cycle a rotating-priority picker chooses one eligible slot. The search starts just after the slot issued last. The registered result reports the slot index, the owning block's identifier and the lane mask. Moving from one warp to another costs no cycle, so every cycle with at least one eligible warp produces an issue. A cycle with none produces an issue-valid-low bubble. When a warp finishes, the core names its slot on the retire port, and that slot returns to the free pool.

Top module: `warp_sched`

## Requirements
- R1: After reset no warp is resident, `issue_valid_o` is low and `blk_ready_o` is high for any block of 1 to 32 threads.
- R2: An accepted block of T threads (1 ≤ T ≤ MAX_THREADS) creates ceil(T/32) warps. One warp per cycle is placed in the lowest-numbered free slot, starting in the cycle after acceptance.
- R3: Bit i of a warp's lane mask enables lane i. Every warp has all 32 bits set, except the last warp of a block with T mod 32 = r ≠ 0, which has only bits 0 to r-1 set.
- R4: `blk_ready_o` is high only while no block is being split and the number of free slots is at least the number of warps the offered block needs. A block is accepted in a cycle where `blk_valid_i` and `blk_ready_o` are both high.
- R5: A slot is eligible in a cycle when it is occupied, its bit in `warp_rdy_i` is high, and it is not being retired in that cycle. Only an eligible slot is ever issued.
- R6: The issued slot is the first eligible slot in ascending circular order after the slot issued last. After reset the search starts at slot 0.
- R7: If any slot is eligible in cycle c, `issue_valid_o` is high in cycle c+1. Back-to-back cycles may issue different warps with no gap.
- R8: If no slot is eligible in cycle c, `issue_valid_o` is low in cycle c+1.
- R9: A cycle with `retire_i` high frees slot `retire_warp_i` at the next edge. That slot cannot be issued in the retire cycle or afterwards, and it counts as free for admission.
- R10: `issue_block_o` and `issue_mask_o` carry the identifier and lane mask recorded for the issued slot when its block was admitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_valid_i | input | 1 | A block is offered |
| blk_threads_i | input | THR_W (10) | Thread count of the offered block |
| blk_id_i | input | BLK_ID_W (4) | Identifier of the offered block |
| blk_ready_o | output | 1 | The offered block can be accepted |
| warp_rdy_i | input | NUM_SLOTS (24) | Operand-ready bit per slot |
| retire_i | input | 1 | Retire the named slot |
| retire_warp_i | input | SLOT_W (5) | Slot to retire |
| issue_valid_o | output | 1 | A warp issues this cycle |
| issue_warp_o | output | SLOT_W (5) | Issued slot |
| issue_block_o | output | BLK_ID_W (4) | Block identifier of the issued warp |
| issue_mask_o | output | 32 | Active-lane mask of the issued warp |

## Verification
The bench builds the block with its defaults: 24 slots, blocks of up to 512 threads and 4-bit block identifiers. Those values allow a full table of three 256-thread blocks and the largest 16-warp block. They also allow tails of 1, 4, 31 and 32 lanes. A full table makes the capacity refusal and its release by a single retire reachable. A sparse pattern of ready bits exercises rotation across the wrap point, and a retire coinciding with readiness exercises the race between the two.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int WARP_LANES = 32;
  localparam int LANE_SH    = $clog2(WARP_LANES);
  typedef logic [WARP_LANES-1:0] lane_mask_t;
endpackage

// File: rtl/ws_block_splitter.sv
module ws_block_splitter
  import warp_sched_pkg::*;
#(
  parameter int NUM_SLOTS   = 24,
  parameter int MAX_THREADS = 512,
  parameter int BLK_ID_W    = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int THR_W  = $clog2(MAX_THREADS + 1),
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 blk_valid_i,
  input  logic [THR_W-1:0]     blk_threads_i,
  input  logic [BLK_ID_W-1:0]  blk_id_i,
  input  logic [NUM_SLOTS-1:0] slot_free_i,
  output logic                 blk_ready_o,
  output logic                 alloc_we_o,
  output logic [SLOT_W-1:0]    alloc_slot_o,
  output logic [BLK_ID_W-1:0]  alloc_blk_o,
  output lane_mask_t           alloc_mask_o
);
  logic [THR_W-1:0]    rem_q;
  logic [BLK_ID_W-1:0] blk_q;
  logic [THR_W:0]      need;
  logic [CNT_W-1:0]    free_cnt;
  logic                busy;

  assign busy = (rem_q != '0);
  assign need = ({1'b0, blk_threads_i} + (THR_W+1)'(WARP_LANES - 1)) >> LANE_SH;

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < NUM_SLOTS; i++) free_cnt = free_cnt + CNT_W'(slot_free_i[i]);
  end

  assign blk_ready_o = !busy && ((THR_W+1)'(free_cnt) >= need);

  always_comb begin
    alloc_slot_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (slot_free_i[i]) alloc_slot_o = SLOT_W'(i);
  end

  assign alloc_we_o  = busy;
  assign alloc_blk_o = blk_q;
  // partial tail keeps only the low lanes
  assign alloc_mask_o = (rem_q >= THR_W'(WARP_LANES)) ? '1 :
                        (lane_mask_t'(1) << rem_q[LANE_SH-1:0]) - lane_mask_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      blk_q <= '0;
    end else if (busy) begin
      rem_q <= (rem_q > THR_W'(WARP_LANES)) ? rem_q - THR_W'(WARP_LANES) : '0;
    end else if (blk_valid_i && blk_ready_o) begin
      rem_q <= blk_threads_i;
      blk_q <= blk_id_i;
    end
  end

  assert_slot_avail_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (|slot_free_i));

  assert_no_accept_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !blk_ready_o);
endmodule

// File: rtl/ws_warp_table.sv
module ws_warp_table
  import warp_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int BLK_ID_W  = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                alloc_we_i,
  input  logic [SLOT_W-1:0]                   alloc_slot_i,
  input  logic [BLK_ID_W-1:0]                 alloc_blk_i,
  input  lane_mask_t                          alloc_mask_i,
  input  logic                                retire_i,
  input  logic [SLOT_W-1:0]                   retire_slot_i,
  output logic [NUM_SLOTS-1:0]                valid_o,
  output logic [NUM_SLOTS-1:0][BLK_ID_W-1:0]  blk_o,
  output lane_mask_t [NUM_SLOTS-1:0]          mask_o
);
  logic [NUM_SLOTS-1:0]               valid_q;
  logic [NUM_SLOTS-1:0][BLK_ID_W-1:0] blk_q;
  lane_mask_t [NUM_SLOTS-1:0]         mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      blk_q   <= '0;
      mask_q  <= '0;
    end else begin
      if (retire_i && (int'(retire_slot_i) < NUM_SLOTS)) valid_q[retire_slot_i] <= 1'b0;
      // a write lands on a free slot, so it overrides a stray retire
      if (alloc_we_i) begin
        valid_q[alloc_slot_i] <= 1'b1;
        blk_q[alloc_slot_i]   <= alloc_blk_i;
        mask_q[alloc_slot_i]  <= alloc_mask_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign blk_o   = blk_q;
  assign mask_o  = mask_q;

  assert_alloc_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_we_i |-> !valid_q[alloc_slot_i]);

  assert_alloc_occupies_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_we_i |=> valid_q[$past(alloc_slot_i)]);
endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
  parameter int NUM_SLOTS = 24,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] elig_i,
  input  logic [SLOT_W-1:0]    last_i,
  output logic                 gnt_valid_o,
  output logic [SLOT_W-1:0]    gnt_idx_o
);
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int i = 1; i <= NUM_SLOTS; i++) begin
      int k;
      k = int'(last_i) + i;
      if (k >= NUM_SLOTS) k = k - NUM_SLOTS;
      if (!gnt_valid_o && elig_i[k]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = SLOT_W'(k);
      end
    end
  end
endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_SLOTS   = 24,
  parameter int MAX_THREADS = 512,
  parameter int BLK_ID_W    = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int THR_W  = $clog2(MAX_THREADS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 blk_valid_i,
  input  logic [THR_W-1:0]     blk_threads_i,
  input  logic [BLK_ID_W-1:0]  blk_id_i,
  output logic                 blk_ready_o,
  input  logic [NUM_SLOTS-1:0] warp_rdy_i,
  input  logic                 retire_i,
  input  logic [SLOT_W-1:0]    retire_warp_i,
  output logic                 issue_valid_o,
  output logic [SLOT_W-1:0]    issue_warp_o,
  output logic [BLK_ID_W-1:0]  issue_block_o,
  output logic [WARP_LANES-1:0] issue_mask_o
);
  logic                               alloc_we;
  logic [SLOT_W-1:0]                  alloc_slot;
  logic [BLK_ID_W-1:0]                alloc_blk;
  lane_mask_t                         alloc_mask;
  logic [NUM_SLOTS-1:0]               slot_valid;
  logic [NUM_SLOTS-1:0][BLK_ID_W-1:0] slot_blk;
  lane_mask_t [NUM_SLOTS-1:0]         slot_mask;
  logic [NUM_SLOTS-1:0]               retire_hot;
  logic [NUM_SLOTS-1:0]               elig;
  logic                               gnt_valid;
  logic [SLOT_W-1:0]                  gnt_idx;
  logic [SLOT_W-1:0]                  last_q;

  ws_block_splitter #(
    .NUM_SLOTS(NUM_SLOTS), .MAX_THREADS(MAX_THREADS), .BLK_ID_W(BLK_ID_W)
  ) u_split (
    .clk_i, .rst_ni, .blk_valid_i, .blk_threads_i, .blk_id_i,
    .slot_free_i (~slot_valid),
    .blk_ready_o,
    .alloc_we_o  (alloc_we),
    .alloc_slot_o(alloc_slot),
    .alloc_blk_o (alloc_blk),
    .alloc_mask_o(alloc_mask)
  );

  ws_warp_table #(.NUM_SLOTS(NUM_SLOTS), .BLK_ID_W(BLK_ID_W)) u_table (
    .clk_i, .rst_ni,
    .alloc_we_i   (alloc_we),
    .alloc_slot_i (alloc_slot),
    .alloc_blk_i  (alloc_blk),
    .alloc_mask_i (alloc_mask),
    .retire_i,
    .retire_slot_i(retire_warp_i),
    .valid_o      (slot_valid),
    .blk_o        (slot_blk),
    .mask_o       (slot_mask)
  );

  always_comb begin
    retire_hot = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      retire_hot[i] = retire_i && (int'(retire_warp_i) == i);
  end

  assign elig = slot_valid & warp_rdy_i & ~retire_hot;

  ws_rr_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .elig_i     (elig),
    .last_i     (last_q),
    .gnt_valid_o(gnt_valid),
    .gnt_idx_o  (gnt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q        <= SLOT_W'(NUM_SLOTS - 1);
      issue_valid_o <= 1'b0;
      issue_warp_o  <= '0;
      issue_block_o <= '0;
      issue_mask_o  <= '0;
    end else begin
      issue_valid_o <= gnt_valid;
      if (gnt_valid) begin
        last_q        <= gnt_idx;
        issue_warp_o  <= gnt_idx;
        issue_block_o <= slot_blk[gnt_idx];
        issue_mask_o  <= slot_mask[gnt_idx];
      end
    end
  end

  assert_issue_elig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid |-> (slot_valid[gnt_idx] && warp_rdy_i[gnt_idx]));

  assert_no_retired_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid && retire_i) |-> (gnt_idx != retire_warp_i));

  assert_no_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|elig) |=> issue_valid_o);

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|elig) |=> !issue_valid_o);

  assert_mask_lane0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> issue_mask_o[0]);
endmodule

// File: tb/warp_sched_test.sv
`timescale 1ns/1ps
module warp_sched_test;
  localparam int NS   = 24;
  localparam int THRW = 10;
  localparam int BW   = 4;
  localparam int SW   = 5;

  typedef struct packed {
    logic [9:0] threads;
    logic [3:0] id;
    logic [4:0] warps;
    logic [5:0] tail;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{10'd1,   4'd1, 5'd1,  6'd1},
    '{10'd31,  4'd2, 5'd1,  6'd31},
    '{10'd32,  4'd3, 5'd1,  6'd32},
    '{10'd33,  4'd4, 5'd2,  6'd1},
    '{10'd64,  4'd5, 5'd2,  6'd32},
    '{10'd100, 4'd6, 5'd4,  6'd4},
    '{10'd256, 4'd7, 5'd8,  6'd32},
    '{10'd512, 4'd8, 5'd16, 6'd32}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            blk_valid = 1'b0;
  logic [THRW-1:0] blk_threads = '0;
  logic [BW-1:0]   blk_id = '0;
  logic            blk_ready;
  logic [NS-1:0]   rdy = '0;
  logic            retire = 1'b0;
  logic [SW-1:0]   retire_id = '0;
  logic            iv;
  logic [SW-1:0]   iw;
  logic [BW-1:0]   ib;
  logic [31:0]     im;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_ptr = NS - 1;
  logic [NS-1:0] occ = '0;
  logic [BW-1:0] mblk [NS];
  logic [31:0]   mmask [NS];

  always #2.5 clk = ~clk;

  warp_sched uut (
    .clk_i(clk), .rst_ni(rst_n),
    .blk_valid_i(blk_valid), .blk_threads_i(blk_threads), .blk_id_i(blk_id),
    .blk_ready_o(blk_ready), .warp_rdy_i(rdy),
    .retire_i(retire), .retire_warp_i(retire_id),
    .issue_valid_o(iv), .issue_warp_o(iw), .issue_block_o(ib), .issue_mask_o(im)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tail_mask(input int lanes);
    return (lanes >= 32) ? 32'hffff_ffff : ((32'd1 << lanes) - 32'd1);
  endfunction

  // one clock; checks the issue produced from eligibility el
  task automatic tick(input logic [NS-1:0] el, input string req);
    bit found = 1'b0;
    int w = 0;
    for (int i = 1; i <= NS; i++) begin
      int k = (exp_ptr + i) % NS;
      if (!found && el[k]) begin found = 1'b1; w = k; end
    end
    @(posedge clk); @(negedge clk);
    check(iv == found, req, 32'(iv), 32'(found));
    if (found && iv) begin
      exp_ptr = w;
      check(int'(iw) == w, {req, " R6 slot"}, 32'(iw), 32'(w));
      check(ib == mblk[w], {req, " R10 block"}, 32'(ib), 32'(mblk[w]));
      check(im == mmask[w], {req, " R3 mask"}, im, mmask[w]);
    end
  endtask

  task automatic admit(input int threads, input logic [BW-1:0] id);
    int n = (threads + 31) / 32;
    blk_threads = THRW'(threads);
    blk_id = id;
    blk_valid = 1'b1;
    #0.1;
    check(blk_ready == 1'b1, "R4 ready with room", 32'(blk_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    blk_valid = 1'b0;
    for (int w = 0; w < n; w++) begin
      int s = -1;
      for (int i = NS - 1; i >= 0; i--) if (!occ[i]) s = i;
      occ[s] = 1'b1;
      mblk[s] = id;
      mmask[s] = (w == n - 1) ? tail_mask(threads - 32 * w) : 32'hffff_ffff;
    end
    for (int c = 0; c <= n; c++) tick('0, "R8 idle during split");
  endtask

  task automatic retire_slot(input int s);
    retire = 1'b1;
    retire_id = SW'(s);
    tick(occ & rdy & ~(NS'(1) << s), "R9 retire cycle");
    occ[s] = 1'b0;
    retire = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin mblk[i] = '0; mmask[i] = '0; end
    blk_threads = 10'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(iv == 1'b0, "R1 no issue after reset", 32'(iv), 32'd0);
    check(blk_ready == 1'b1, "R1 ready after reset", 32'(blk_ready), 32'd1);

    // table walk: split, tail mask, rotation over occupied slots
    for (int v = 0; v < 8; v++) begin
      admit(int'(VECS[v].threads), VECS[v].id);
      check(32'($countones(occ)) == 32'(VECS[v].warps), "R2 warp count", 32'($countones(occ)), 32'(VECS[v].warps));
      rdy = '1;
      for (int c = 0; c <= int'(VECS[v].warps); c++) tick(occ & rdy, "R7 all ready");
      rdy = '0;
      for (int s = 0; s < int'(VECS[v].warps); s++) retire_slot(s);
    end

    // capacity: three 256-thread blocks fill 24 slots
    admit(256, 4'd1);
    admit(256, 4'd2);
    admit(256, 4'd3);
    blk_threads = 10'd1;
    #0.1;
    check(blk_ready == 1'b0, "R4 full table refuses", 32'(blk_ready), 32'd0);
    rdy = '1;
    for (int c = 0; c < 30; c++) tick(occ & rdy, "R7 back-to-back issue");
    rdy = '0;
    retire_slot(5);
    blk_threads = 10'd1;
    #0.1;
    check(blk_ready == 1'b1, "R9 freed slot admits", 32'(blk_ready), 32'd1);
    blk_threads = 10'd33;
    #0.1;
    check(blk_ready == 1'b0, "R4 two warps need two slots", 32'(blk_ready), 32'd0);
    admit(1, 4'd9);
    check(occ[5] == 1'b1, "R2 lowest free slot", 32'(occ[5]), 32'd1);

    // sparse readiness across the wrap point
    rdy = '0;
    rdy[5] = 1'b1;
    rdy[20] = 1'b1;
    for (int c = 0; c < 5; c++) tick(occ & rdy, "R5 sparse ready");

    // retire coinciding with readiness
    rdy = '0;
    rdy[7] = 1'b1;
    retire_slot(7);
    tick(occ & rdy, "R9 retired slot stays idle");
    rdy = '0;
    tick('0, "R8 nothing ready");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule